// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block tracks the coherence state of every line in a small direct-mapped write-back cache. Each line is in one of four states: Modified, Exclusive, Shared or Invalid. The processor side presents one read or write at a time and holds it until the block reports a hit. A request that the line's state cannot satisfy stalls. The block then puts a bus transaction forward and waits for a grant. The grant cycle is the one in which the transaction takes effect on every cache.

Several copies of the block sit on one bus. Each copy watches the transactions of its peers. A copy answers a peer's read on a line it holds by raising a wired-OR shared signal. It asks its datapath to supply the data when it holds the only dirty copy. When a peer announces that it will modify a line, the copy drops its own version. The shared response seen at the grant of a read miss decides whether the new line is held exclusively. That choice lets a later write to a private line finish without using the bus.

Top module: `mesi_snoop_ctl`

## Requirements
- R1: A read that misses puts a bus read (`bus_cmd` = 1) on the bus. If `shared_in` is 0 in the grant cycle, the line is filled as Exclusive.
- R2: If `shared_in` is 1 in the grant cycle of a bus read, the line is filled as Shared. A later write to that line then issues a read-exclusive.
- R3: `shared_out` is high in any cycle where a snooped bus read hits a line this cache holds in a valid state.
- R4: A write to an Exclusive line completes with `cpu_hit` and no bus request, and the line becomes Modified.
- R5: A write to a Shared or absent line issues a read-exclusive (`bus_cmd` = 2) and leaves the line Modified, so the next write hits with no bus activity.
- R6: `flush_req` is high in a cycle where a snooped read or read-exclusive hits a Modified line, and only in the cache that holds it Modified.
- R7: A snooped bus read moves a Modified or Exclusive line to Shared. A snooped read-exclusive moves any valid line to Invalid.
- R8: A miss that displaces a Modified line first issues a write-back (`bus_cmd` = 3) carrying the old line's address, and then the miss transaction. Displacing an Exclusive or Shared line causes no extra transaction.
- R9: Reads to a valid line and writes to a Modified line raise `cpu_hit` in the request cycle, with `bus_req` low.
- R10: After reset every line is Invalid, and `bus_req`, `shared_out` and `flush_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access valid, held until hit |
| cpu_we | input | 1 | Access is a write |
| cpu_addr | input | ADDR_W | Line address: tag above index |
| cpu_hit | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Access waits |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 none, 1 read, 2 read-exclusive, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_gnt | input | 1 | Transaction takes effect this cycle |
| shared_in | input | 1 | OR of the peers' shared responses |
| snp_valid | input | 1 | A peer transaction is on the bus |
| snp_cmd | input | 2 | Peer transaction code |
| snp_addr | input | ADDR_W | Peer transaction address |
| shared_out | output | 1 | This cache holds the snooped line |
| flush_req | output | 1 | Datapath must supply the dirty line |

## Verification
The in-design assertions follow every state change on each cycle. After a read fill the line is valid. After a write hit the line is Modified. After a snooped read-exclusive the line is Invalid. After a write-back grant the line is empty. After a flush the line is no longer Modified. Other behaviour can only be seen in the bench's two-cache scenarios. This covers the choice between Exclusive and Shared driven by the peer's shared response, and the silent upgrade of an Exclusive line. It also covers the write-back that comes before a miss on a dirty line, and the silent eviction of a clean line. Each of these shows up as the sequence of bus commands that a later access produces.

// File: rtl/mesi_snoop_ctl.sv
module mesi_snoop_ctl #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 4,
  localparam int ADDR_W = IDX_W + TAG_W,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_hit,
  output logic              cpu_stall,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              shared_out,
  output logic              flush_req
);
  localparam logic [1:0] C_NONE = 2'd0, C_RD = 2'd1, C_RDX = 2'd2, C_WB = 2'd3;
  localparam logic [1:0] S_I = 2'd0, S_S = 2'd1, S_E = 2'd2, S_M = 2'd3;

  logic [1:0]       st [LINES];
  logic [TAG_W-1:0] tg [LINES];

  logic [IDX_W-1:0] idx, s_idx;
  logic [TAG_W-1:0] tag, s_tag;
  logic [1:0] line_st, s_st;
  logic tag_eq, present, local_ok, conflict, need_wb, snp_hit, granted;

  assign idx   = cpu_addr[IDX_W-1:0];
  assign tag   = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];

  assign line_st  = st[idx];
  assign tag_eq   = tg[idx] == tag;
  assign present  = (line_st != S_I) && tag_eq;
  assign local_ok = present && (!cpu_we || line_st == S_M || line_st == S_E);
  assign conflict = snp_valid && (s_idx == idx);
  assign need_wb  = (line_st == S_M) && !tag_eq;

  assign cpu_hit   = cpu_req && local_ok && !conflict;
  assign cpu_stall = cpu_req && !cpu_hit;
  assign bus_req   = cpu_req && !local_ok && !conflict;
  assign bus_cmd   = !bus_req ? C_NONE : need_wb ? C_WB : cpu_we ? C_RDX : C_RD;
  assign bus_addr  = need_wb ? {tg[idx], idx} : cpu_addr;
  assign granted   = bus_req && bus_gnt;

  assign s_st       = st[s_idx];
  assign snp_hit    = snp_valid && (s_st != S_I) && (tg[s_idx] == s_tag);
  assign shared_out = snp_hit && (snp_cmd == C_RD);
  assign flush_req  = snp_hit && (s_st == S_M) && (snp_cmd == C_RD || snp_cmd == C_RDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st[i] <= S_I;
        tg[i] <= '0;
      end
    end else begin
      if (snp_hit && snp_cmd == C_RD)  st[s_idx] <= S_S;
      if (snp_hit && snp_cmd == C_RDX) st[s_idx] <= S_I;
      if (cpu_hit && cpu_we && line_st == S_E) st[idx] <= S_M;
      if (granted) begin
        case (bus_cmd)
          C_WB:  st[idx] <= S_I;
          C_RD:  begin st[idx] <= shared_in ? S_S : S_E; tg[idx] <= tag; end
          C_RDX: begin st[idx] <= S_M; tg[idx] <= tag; end
          default: ;
        endcase
      end
    end
  end

  // R1
  fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && bus_cmd == C_RD) |=> (st[$past(idx)] == S_S || st[$past(idx)] == S_E));

  // R4
  write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hit && cpu_we) |=> (st[$past(idx)] == S_M));

  // R7
  snoop_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_hit && snp_cmd == C_RDX) |=> (st[$past(s_idx)] == S_I));

  // R8
  wb_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && bus_cmd == C_WB) |=> (st[$past(idx)] == S_I));

  // R6
  flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (st[$past(s_idx)] != S_M));
endmodule

// File: tb/sim_mesi_snoop_ctl.sv
module sim_mesi_snoop_ctl;
  localparam int AW = 7;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic r0 = 0, r1 = 0, w0 = 0, w1 = 0;
  logic [AW-1:0] a0 = '0, a1 = '0;
  logic h0, h1, st0, st1, q0, q1, sh0, sh1, f0, f1, g0, g1;
  logic [1:0] c0, c1;
  logic [AW-1:0] ba0, ba1;

  assign g0 = q0;
  assign g1 = q1 && !q0;

  mesi_snoop_ctl u0 (.clk(clk), .rst_n(rst_n), .cpu_req(r0), .cpu_we(w0), .cpu_addr(a0),
    .cpu_hit(h0), .cpu_stall(st0), .bus_req(q0), .bus_cmd(c0), .bus_addr(ba0), .bus_gnt(g0),
    .shared_in(sh1), .snp_valid(g1), .snp_cmd(c1), .snp_addr(ba1), .shared_out(sh0), .flush_req(f0));
  mesi_snoop_ctl u1 (.clk(clk), .rst_n(rst_n), .cpu_req(r1), .cpu_we(w1), .cpu_addr(a1),
    .cpu_hit(h1), .cpu_stall(st1), .bus_req(q1), .bus_cmd(c1), .bus_addr(ba1), .bus_gnt(g1),
    .shared_in(sh0), .snp_valid(g0), .snp_cmd(c0), .snp_addr(ba0), .shared_out(sh1), .flush_req(f1));

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ntx [2];
  logic [1:0] cmd_log [2][4];
  logic [AW-1:0] adr_log [2][4];
  int nfl [2];
  logic shr [2];

  always @(posedge clk) begin
    cyc++;
    if (g0) begin
      if (ntx[0] < 4) begin cmd_log[0][ntx[0]] = c0; adr_log[0][ntx[0]] = ba0; end
      ntx[0]++; shr[0] = sh1;
    end
    if (g1) begin
      if (ntx[1] < 4) begin cmd_log[1][ntx[1]] = c1; adr_log[1][ntx[1]] = ba1; end
      ntx[1]++; shr[1] = sh0;
    end
    if (f0) nfl[0]++;
    if (f1) nfl[1]++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int i = 0; i < 2; i++) begin ntx[i] = 0; nfl[i] = 0; shr[i] = 0; end
  endtask

  task automatic acc(input int id, input logic we, input logic [AW-1:0] ad, output int waited);
    bit done = 0;
    waited = 0;
    clr();
    @(negedge clk);
    if (id == 0) begin r0 = 1; w0 = we; a0 = ad; end
    else begin r1 = 1; w1 = we; a1 = ad; end
    for (int k = 0; k < 50; k++) begin
      #1;
      if ((id == 0 && h0) || (id == 1 && h1)) begin done = 1; break; end
      waited++;
      @(negedge clk);
    end
    if (!done) chk("access timeout", 0, 1);
    @(posedge clk); #1;
    r0 = 0; r1 = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R10 bus_req0", q0, 0); chk("R10 bus_req1", q1, 0);
    chk("R10 shared", sh0 | sh1, 0); chk("R10 flush", f0 | f1, 0);
    r0 = 1; w0 = 0; a0 = 7'h12; #1;
    chk("R10 first access stalls", st0, 1);
    r0 = 0;
  endtask

  task automatic t_read_excl();
    int w;
    acc(0, 0, 7'h12, w);
    chk("R1 tx count", ntx[0], 1); chk("R1 cmd read", cmd_log[0][0], 1);
    chk("R1 shared sample", shr[0], 0);
    acc(0, 0, 7'h12, w);
    chk("R9 read hit wait", w, 0); chk("R9 read hit no tx", ntx[0], 0);
    acc(0, 1, 7'h12, w);
    chk("R4 exclusive write no tx", ntx[0], 0); chk("R4 write wait", w, 0);
  endtask

  task automatic t_snoop_mod();
    int w;
    acc(1, 0, 7'h12, w);
    chk("R3 shared seen by reader", shr[1], 1); chk("R6 owner flush", nfl[0], 1);
    chk("R6 reader no flush", nfl[1], 0); chk("R1 reader cmd", cmd_log[1][0], 1);
    acc(0, 1, 7'h12, w);
    chk("R7 M->S upgrade needs RDX", ntx[0], 1); chk("R7 cmd rdx", cmd_log[0][0], 2);
    acc(1, 0, 7'h12, w);
    chk("R7 RDX invalidated peer", ntx[1], 1); chk("R6 flush after RDX owner", nfl[0], 1);
  endtask

  task automatic t_upgrade();
    int w;
    acc(1, 1, 7'h12, w);
    chk("R2 shared write cmd rdx", cmd_log[1][0], 2); chk("R2 tx count", ntx[1], 1);
    acc(1, 1, 7'h12, w);
    chk("R5 M write no tx", ntx[1], 0); chk("R9 M write wait", w, 0);
  endtask

  task automatic t_evict();
    int w;
    acc(1, 1, 7'h2A, w);
    chk("R8 evict tx count", ntx[1], 2); chk("R8 first cmd wb", cmd_log[1][0], 3);
    chk("R8 wb addr", adr_log[1][0], 7'h12); chk("R8 second cmd rdx", cmd_log[1][1], 2);
    chk("R8 miss addr", adr_log[1][1], 7'h2A);
    acc(0, 0, 7'h2A, w);
    chk("R6 flush on read of M", nfl[1], 1); chk("R2 filled shared", shr[0], 1);
    acc(0, 0, 7'h32, w);
    chk("R8 silent clean evict", ntx[0], 1); chk("R8 cmd read", cmd_log[0][0], 1);
  endtask

  task automatic t_snoop_excl();
    int w;
    acc(1, 0, 7'h32, w);
    chk("R3 E holder asserts shared", shr[1], 1); chk("R6 no flush from E", nfl[0], 0);
    acc(0, 1, 7'h32, w);
    chk("R7 E->S then write rdx", ntx[0], 1); chk("R7 cmd", cmd_log[0][0], 2);
    acc(1, 0, 7'h32, w);
    chk("R7 reader invalidated", ntx[1], 1); chk("R6 flush once", nfl[0] + nfl[1], 1);
  endtask

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_read_excl();
    t_snoop_mod();
    t_upgrade();
    t_evict();
    t_snoop_excl();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule